// File: doc/BRIEF.md
# USB Device Interrupt Enable and Status Unit

This block sits between the event outputs of a USB device engine and the CPU. It takes single-cycle event pulses and records them in status flags that the CPU clears. It drives one active-high interrupt line. The events are VBUS change, resume, start-of-frame, bus reset, SetAddress done, SetConfiguration done, suspend, the four control-transfer stage events, and per-endpoint buffer ready, not-ready and empty/size-error conditions.

Gating happens at two levels. The low byte of the 16-bit enable word holds per-cause sub-enables. They decide whether a bus-state event sets the device-state flag, and whether a control-transfer event sets the control-transfer flag. The high byte holds top-level enables. They decide which recorded flags reach the interrupt line. Each flag is ANDed with its top-level enable, and the results are ORed onto the interrupt line. Clearing a top-level enable therefore silences the line but keeps the flag.

The CPU uses a simple bus: byte address, write strobe, write data, and a combinational read-data port. Address 0x10 is the enable word, which the CPU can read and write. Address 0x12 is the main status word. Address 0x14 holds the endpoint ready and not-ready vectors. Address 0x16 holds the endpoint empty vector. Status bits are cleared by writing 1 to them.

Top module: `usb_irq_gate`

## Requirements
- R1: After reset, reads of 0x10, 0x12, 0x14 and 0x16 all return 0 and `irq_out` is 0.
- R2: A write to 0x10 stores all 16 bits, and a read of 0x10 returns them. A write to any address other than 0x10 leaves the enable word unchanged.
- R3: Bit 3 of 0x12 is the device-state flag. Each of the following events sets it only if its sub-enable bit in the enable word is 1: bus reset (bit 7), SetAddress done (bit 6), SetConfiguration done (bit 5) and suspend (bit 4). An event whose sub-enable bit is 0 leaves the flag unchanged.
- R4: Bit 4 of 0x12 is the control-transfer flag. Each of the following events sets it only if its sub-enable bit is 1: entry to the control-write status stage (bit 3), entry to the control-read status stage (bit 2), normal completion (bit 1) and sequence error (bit 0).
- R5: VBUS change, resume and SOF pulses always set bits 0, 1 and 2 of 0x12, in that order. These bits raise `irq_out` when enable bits 15, 14 and 13 are set, in that order.
- R6: An endpoint pulse on lane n sets bit n of its vector. The ready vector reads at 0x14 bits 5:0, the not-ready vector at 0x14 bits 13:8 and the empty vector at 0x16 bits 5:0. The OR of each vector reads at 0x12 bits 7 (ready), 6 (not-ready) and 5 (empty). Those ORs are gated into `irq_out` by enable bits 8, 9 and 10 respectively.
- R7: `irq_out` is the OR over all sources of flag AND top-level enable, and it follows register state in the same cycle. The device-state and control-transfer flags are gated by enable bits 12 and 11. Clearing an enable drops `irq_out` while the flag stays set.
- R8: Writing a 1 to a status bit at 0x12 (bits 4:0), 0x14 or 0x16 clears that bit. Bits written with 0 keep their value. Bits 7:5 of 0x12 cannot be written.
- R9: When a set event and a clear write hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | CPU byte address |
| bus_wr | input | 1 | CPU write strobe, one cycle per write |
| bus_wdata | input | 16 | CPU write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| ev_vbus | input | 1 | VBUS change pulse |
| ev_resume | input | 1 | Resume detect pulse |
| ev_sof | input | 1 | Start-of-frame pulse |
| ev_bus_reset | input | 1 | USB bus reset detect pulse |
| ev_set_addr | input | 1 | SetAddress completed pulse |
| ev_set_cfg | input | 1 | SetConfiguration completed pulse |
| ev_suspend | input | 1 | Suspend detect pulse |
| ev_wr_status | input | 1 | Control write entered status stage |
| ev_rd_status | input | 1 | Control read entered status stage |
| ev_ctl_done | input | 1 | Control transfer completed normally |
| ev_seq_err | input | 1 | Control transfer sequence error |
| ep_ready | input | 6 | Per-endpoint buffer ready pulses |
| ep_not_ready | input | 6 | Per-endpoint buffer not-ready pulses |
| ep_empty | input | 6 | Per-endpoint buffer empty/size-error pulses |
| irq_out | output | 1 | Interrupt request, active high |

## Verification
Two functions can land in the same cycle. The first is a CPU write-one-to-clear of a status bit. The second is an engine pulse that sets the same bit. The bench provokes this with a single cycle that carries both the VBUS pulse and a clear write of bit 0 at 0x12. It repeats the case with an endpoint ready pulse against a clear of its lane at 0x14. In each case the bit must read back as 1 afterwards, and a later clear write alone must then read back 0. The bench also drives a sub-event whose sub-enable is 0 in the same cycle as a clear of the flag. The flag must end cleared, which shows that a masked event does not count as a set.

// File: rtl/usb_irq_pkg.sv
// Package: shared constants for the USB interrupt gating unit.
// Assumes a 16-bit register file on a byte-addressed CPU bus.
package usb_irq_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 8;
    localparam int NUM_EP   = 6;
    localparam int MAIN_W   = 5;   // vbus, resume, sof, dev-state, ctl-transfer

    localparam logic [ADDR_W-1:0] A_ENABLE = 8'h10;
    localparam logic [ADDR_W-1:0] A_MAIN   = 8'h12;
    localparam logic [ADDR_W-1:0] A_EPRN   = 8'h14;
    localparam logic [ADDR_W-1:0] A_EPEM   = 8'h16;

    // main status bit positions
    localparam int S_VBUS = 0;
    localparam int S_RSM  = 1;
    localparam int S_SOF  = 2;
    localparam int S_DEV  = 3;
    localparam int S_CTL  = 4;

    // enable word bit positions
    localparam int E_VBUS = 15;
    localparam int E_RSM  = 14;
    localparam int E_SOF  = 13;
    localparam int E_DEV  = 12;
    localparam int E_CTL  = 11;
    localparam int E_EMP  = 10;
    localparam int E_NRDY = 9;
    localparam int E_RDY  = 8;
    localparam int E_URST = 7;
    localparam int E_SADR = 6;
    localparam int E_SCFG = 5;
    localparam int E_SUSP = 4;
    localparam int E_WDST = 3;
    localparam int E_RDST = 2;
    localparam int E_CMPL = 1;
    localparam int E_SERR = 0;
endpackage

// File: rtl/usb_irq_enreg.sv
// Module: 16-bit read/write enable word.
// Assumes single-cycle write strobes; reset clears all bits.
module usb_irq_enreg #(
    parameter int W      = 16,
    parameter int AW     = 8,
    parameter logic [AW-1:0] ADDR = 8'h10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  en_q
);
    // Store the CPU write when it targets this register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr && addr == ADDR)
            en_q <= wdata;
    end
endmodule

// File: rtl/usb_irq_flags.sv
// Module: bank of sticky status flags with write-one-to-clear.
// Assumes set and clear vectors are single-cycle; set has priority.
module usb_irq_flags #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    // Per-bit update: clear first, then apply set so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= (q & ~clr) | set;
    end
endmodule

// File: rtl/usb_irq_combine.sv
// Module: top-level gating and OR reduction to the interrupt line.
// Assumes sources are aligned bit-for-bit with the enable byte.
module usb_irq_combine #(
    parameter int N = 8
) (
    input  logic [N-1:0] src,
    input  logic [N-1:0] en,
    output logic         irq
);
    logic [N-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_gate
            assign hit[g] = src[g] & en[g];
        end
    endgenerate

    // Any enabled source asserts the request.
    always_comb irq = |hit;
endmodule

// File: rtl/usb_irq_gate.sv
// Module: USB device interrupt enable/status unit (top).
// Holds the enable word, device/control aggregate flags, direct flags
// and per-endpoint vectors; drives one interrupt request.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module usb_irq_gate
    import usb_irq_pkg::*;
#(
    parameter int EP_N = NUM_EP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_vbus,
    input  logic              ev_resume,
    input  logic              ev_sof,
    input  logic              ev_bus_reset,
    input  logic              ev_set_addr,
    input  logic              ev_set_cfg,
    input  logic              ev_suspend,
    input  logic              ev_wr_status,
    input  logic              ev_rd_status,
    input  logic              ev_ctl_done,
    input  logic              ev_seq_err,
    input  logic [EP_N-1:0]   ep_ready,
    input  logic [EP_N-1:0]   ep_not_ready,
    input  logic [EP_N-1:0]   ep_empty,
    output logic              irq_out
);
    localparam int NSRC   = 8;
    localparam int HI_OFS = 8;

    logic [DATA_W-1:0] en_q;
    logic [MAIN_W-1:0] main_set, main_clr, main_q;
    logic [EP_N-1:0]   rdy_clr, nrdy_clr, emp_clr;
    logic [EP_N-1:0]   rdy_q, nrdy_q, emp_q;
    logic              dev_hit, ctl_hit;
    logic [NSRC-1:0]   src_vec;
    logic [NSRC-1:0]   top_en;

    usb_irq_enreg #(.W(DATA_W), .AW(ADDR_W), .ADDR(A_ENABLE)) i_enreg (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
        .wdata(bus_wdata), .en_q(en_q)
    );

    // Qualify bus-state sub-events with their sub-enables.
    always_comb begin
        dev_hit = (ev_bus_reset & en_q[E_URST]) |
                  (ev_set_addr  & en_q[E_SADR]) |
                  (ev_set_cfg   & en_q[E_SCFG]) |
                  (ev_suspend   & en_q[E_SUSP]);
    end

    // Qualify control-transfer sub-events with their sub-enables.
    always_comb begin
        ctl_hit = (ev_wr_status & en_q[E_WDST]) |
                  (ev_rd_status & en_q[E_RDST]) |
                  (ev_ctl_done  & en_q[E_CMPL]) |
                  (ev_seq_err   & en_q[E_SERR]);
    end

    // Assemble set vector of the main status flags.
    always_comb begin
        main_set        = '0;
        main_set[S_VBUS] = ev_vbus;
        main_set[S_RSM]  = ev_resume;
        main_set[S_SOF]  = ev_sof;
        main_set[S_DEV]  = dev_hit;
        main_set[S_CTL]  = ctl_hit;
    end

    // Decode write-one-to-clear masks for each status register.
    always_comb begin
        main_clr = '0;
        rdy_clr  = '0;
        nrdy_clr = '0;
        emp_clr  = '0;
        if (bus_wr) begin
            if (bus_addr == A_MAIN) main_clr = bus_wdata[MAIN_W-1:0];
            if (bus_addr == A_EPRN) begin
                rdy_clr  = bus_wdata[EP_N-1:0];
                nrdy_clr = bus_wdata[HI_OFS +: EP_N];
            end
            if (bus_addr == A_EPEM) emp_clr = bus_wdata[EP_N-1:0];
        end
    end

    usb_irq_flags #(.W(MAIN_W)) i_main (
        .clk(clk), .rst_n(rst_n), .set(main_set), .clr(main_clr), .q(main_q)
    );
    usb_irq_flags #(.W(EP_N)) i_rdy (
        .clk(clk), .rst_n(rst_n), .set(ep_ready), .clr(rdy_clr), .q(rdy_q)
    );
    usb_irq_flags #(.W(EP_N)) i_nrdy (
        .clk(clk), .rst_n(rst_n), .set(ep_not_ready), .clr(nrdy_clr), .q(nrdy_q)
    );
    usb_irq_flags #(.W(EP_N)) i_emp (
        .clk(clk), .rst_n(rst_n), .set(ep_empty), .clr(emp_clr), .q(emp_q)
    );

    // Align sources with enable bits 15..8.
    always_comb begin
        src_vec[E_VBUS-HI_OFS] = main_q[S_VBUS];
        src_vec[E_RSM -HI_OFS] = main_q[S_RSM];
        src_vec[E_SOF -HI_OFS] = main_q[S_SOF];
        src_vec[E_DEV -HI_OFS] = main_q[S_DEV];
        src_vec[E_CTL -HI_OFS] = main_q[S_CTL];
        src_vec[E_EMP -HI_OFS] = |emp_q;
        src_vec[E_NRDY-HI_OFS] = |nrdy_q;
        src_vec[E_RDY -HI_OFS] = |rdy_q;
        top_en                 = en_q[HI_OFS +: NSRC];
    end

    usb_irq_combine #(.N(NSRC)) i_comb (
        .src(src_vec), .en(top_en), .irq(irq_out)
    );

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ENABLE: bus_rdata = en_q;
            A_MAIN: begin
                bus_rdata[MAIN_W-1:0] = main_q;
                bus_rdata[5] = |emp_q;
                bus_rdata[6] = |nrdy_q;
                bus_rdata[7] = |rdy_q;
            end
            A_EPRN: begin
                bus_rdata[EP_N-1:0]      = rdy_q;
                bus_rdata[HI_OFS +: EP_N] = nrdy_q;
            end
            A_EPEM: bus_rdata[EP_N-1:0] = emp_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/usb_irq_gate_chk.sv
// Module: assertion checker bound into usb_irq_gate.
// Assumes access to the enable word and flag registers of the top.
module usb_irq_gate_chk #(
    parameter int EP_N = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bus_addr,
    input logic        bus_wr,
    input logic [15:0] bus_wdata,
    input logic        ev_vbus,
    input logic        ev_bus_reset,
    input logic        ev_set_addr,
    input logic        ev_set_cfg,
    input logic        ev_suspend,
    input logic [EP_N-1:0] ep_ready,
    input logic [15:0] en_q,
    input logic [4:0]  main_q,
    input logic [EP_N-1:0] rdy_q,
    input logic        irq_out
);
    logic main_wr, dev_sub;
    always_comb begin
        main_wr = bus_wr && bus_addr == 8'h12;
        dev_sub = (ev_bus_reset && en_q[7]) || (ev_set_addr && en_q[6]) ||
                  (ev_set_cfg && en_q[5]) || (ev_suspend && en_q[4]);
    end

    // R5: a VBUS pulse always records its flag.
    a_r5_vbus_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vbus |=> main_q[0]);

    // R9: set beats a simultaneous clear.
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vbus && main_wr && bus_wdata[0]) |=> main_q[0]);

    // R3: masked sub-events never raise the device-state flag.
    a_r3_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_q[3] && !dev_sub) |=> !main_q[3]);

    // R8: a clear write without a set clears the bit.
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (main_wr && bus_wdata[0] && !ev_vbus) |=> !main_q[0]);

    // R7: no enables, no interrupt.
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[15:8] == 8'h00) |-> !irq_out);

    // R6: an endpoint ready pulse lands in the vector.
    a_r6_ep_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_ready != '0) |=> (rdy_q != '0));
endmodule

bind usb_irq_gate usb_irq_gate_chk #(.EP_N(EP_N)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .ev_vbus(ev_vbus), .ev_bus_reset(ev_bus_reset),
    .ev_set_addr(ev_set_addr), .ev_set_cfg(ev_set_cfg),
    .ev_suspend(ev_suspend), .ep_ready(ep_ready), .en_q(en_q),
    .main_q(main_q), .rdy_q(rdy_q), .irq_out(irq_out)
);

// File: tb/test_usb_irq_gate.sv
// Directed bench for usb_irq_gate.
module test_usb_irq_gate;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  bus_addr = 0;
    logic        bus_wr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic [10:0] ev = 0; // 0 vbus,1 rsm,2 sof,3 urst,4 sadr,5 scfg,6 susp,7 wdst,8 rdst,9 cmpl,10 serr
    logic [5:0]  ep_ready = 0, ep_not_ready = 0, ep_empty = 0;
    logic        irq_out;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    usb_irq_gate i_usb_irq_gate (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_vbus(ev[0]), .ev_resume(ev[1]), .ev_sof(ev[2]),
        .ev_bus_reset(ev[3]), .ev_set_addr(ev[4]), .ev_set_cfg(ev[5]),
        .ev_suspend(ev[6]), .ev_wr_status(ev[7]), .ev_rd_status(ev[8]),
        .ev_ctl_done(ev[9]), .ev_seq_err(ev[10]),
        .ep_ready(ep_ready), .ep_not_ready(ep_not_ready), .ep_empty(ep_empty),
        .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus: optional write plus event pulses.
    task automatic cyc(input logic wr, input logic [7:0] a, input logic [15:0] d,
                       input logic [10:0] e, input logic [5:0] r, input logic [5:0] n,
                       input logic [5:0] m);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        ev = e; ep_ready = r; ep_not_ready = n; ep_empty = m;
        @(negedge clk);
        bus_wr = 0; ev = 0; ep_ready = 0; ep_not_ready = 0; ep_empty = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        cyc(1, a, d, 0, 0, 0, 0);
    endtask

    task automatic pulse(input logic [10:0] e);
        cyc(0, 0, 0, e, 0, 0, 0);
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(8'h10, v); chk("R1 enable", v, 0);
        rd(8'h12, v); chk("R1 main", v, 0);
        rd(8'h14, v); chk("R1 eprn", v, 0);
        rd(8'h16, v); chk("R1 epem", v, 0);
        chk("R1 irq", {15'd0, irq_out}, 0);
    endtask

    task automatic t_enable_rw;
        logic [15:0] v;
        wr(8'h10, 16'hA5C3); rd(8'h10, v); chk("R2 readback", v, 16'hA5C3);
        wr(8'h11, 16'hFFFF); rd(8'h10, v); chk("R2 other addr", v, 16'hA5C3);
        wr(8'h10, 16'h0000); rd(8'h10, v); chk("R2 zero", v, 0);
    endtask

    task automatic t_direct;
        logic [15:0] v;
        pulse(11'b111); rd(8'h12, v); chk("R5 flags", v, 16'h0007);
        chk("R5 irq off", {15'd0, irq_out}, 0);
        wr(8'h10, 16'h4000); chk("R5 resume irq", {15'd0, irq_out}, 1);
        wr(8'h12, 16'h0002); chk("R5 resume cleared", {15'd0, irq_out}, 0);
        wr(8'h10, 16'h2000); chk("R5 sof irq", {15'd0, irq_out}, 1);
        wr(8'h12, 16'h0005); wr(8'h10, 0);
        rd(8'h12, v); chk("R8 cleared", v, 0);
    endtask

    task automatic t_devstate;
        logic [15:0] v;
        pulse(11'b1111000); rd(8'h12, v); chk("R3 all masked", v, 0);
        wr(8'h10, 16'h1040);
        pulse(11'b1101000); rd(8'h12, v); chk("R3 other masked", v, 0);
        chk("R3 irq none", {15'd0, irq_out}, 0);
        pulse(11'b0010000); rd(8'h12, v); chk("R3 setaddr", v, 16'h0008);
        chk("R7 dev irq", {15'd0, irq_out}, 1);
        wr(8'h12, 16'h0008);
        wr(8'h10, 16'h0010); pulse(11'b1000000); rd(8'h12, v);
        chk("R3 suspend", v, 16'h0008);
        chk("R7 dev gated", {15'd0, irq_out}, 0);
        // masked event against a clear: clear must win since no set
        wr(8'h10, 16'h0000);
        cyc(1, 8'h12, 16'h0008, 11'b0001000, 0, 0, 0);
        rd(8'h12, v); chk("R3 masked vs clear", v, 0);
    endtask

    task automatic t_ctl;
        logic [15:0] v;
        wr(8'h10, 16'h0805);
        pulse(11'b01010000000); rd(8'h12, v); chk("R4 masked", v, 0);
        pulse(11'b00100000000); rd(8'h12, v); chk("R4 rdst", v, 16'h0010);
        chk("R7 ctl irq", {15'd0, irq_out}, 1);
        wr(8'h12, 16'h0010);
        pulse(11'b10000000000); rd(8'h12, v); chk("R4 seq err", v, 16'h0010);
        wr(8'h12, 16'h0010); wr(8'h10, 16'h000A);
        pulse(11'b01000000000); rd(8'h12, v); chk("R4 done", v, 16'h0010);
        wr(8'h12, 16'h0010); wr(8'h10, 0);
    endtask

    task automatic t_endpoint;
        logic [15:0] v;
        wr(8'h10, 16'h0100);
        cyc(0, 0, 0, 0, 6'b100000, 0, 0);
        rd(8'h14, v); chk("R6 ready vec", v, 16'h0020);
        rd(8'h12, v); chk("R6 ready any", v, 16'h0080);
        chk("R6 ready irq", {15'd0, irq_out}, 1);
        cyc(0, 0, 0, 0, 0, 6'b000100, 6'b000001);
        rd(8'h14, v); chk("R6 notready vec", v, 16'h0420);
        rd(8'h16, v); chk("R6 empty vec", v, 16'h0001);
        wr(8'h10, 16'h0400); chk("R6 empty irq", {15'd0, irq_out}, 1);
        wr(8'h16, 16'h0001); chk("R8 empty clr irq", {15'd0, irq_out}, 0);
        wr(8'h12, 16'h00E0); rd(8'h12, v); chk("R8 ro bits", v, 16'h00C0);
        wr(8'h14, 16'h0420); rd(8'h14, v); chk("R8 eprn clr", v, 0);
        wr(8'h10, 0);
    endtask

    task automatic t_gate_drop;
        logic [15:0] v;
        wr(8'h10, 16'h8000); pulse(11'b1);
        chk("R7 vbus irq", {15'd0, irq_out}, 1);
        wr(8'h10, 0); chk("R7 dropped", {15'd0, irq_out}, 0);
        rd(8'h12, v); chk("R7 flag kept", v, 16'h0001);
        wr(8'h12, 16'h0000); rd(8'h12, v); chk("R8 zero write", v, 16'h0001);
        wr(8'h12, 16'h0001);
    endtask

    task automatic t_collide;
        logic [15:0] v;
        cyc(1, 8'h12, 16'h0001, 11'b1, 0, 0, 0);
        rd(8'h12, v); chk("R9 vbus set wins", v, 16'h0001);
        wr(8'h12, 16'h0001); rd(8'h12, v); chk("R9 later clear", v, 0);
        cyc(0, 0, 0, 0, 6'b000010, 0, 0);
        cyc(1, 8'h14, 16'h0002, 0, 6'b000010, 0, 0);
        rd(8'h14, v); chk("R9 ep set wins", v, 16'h0002);
        wr(8'h14, 16'h0002); rd(8'h14, v); chk("R9 ep clear", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_enable_rw;
        t_direct;
        t_devstate;
        t_ctl;
        t_endpoint;
        t_gate_drop;
        t_collide;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule